// File: doc/BRIEF.md
# CAN Controller Mode and Status Register

This block is the byte-wide mode and status register of a CAN protocol controller, placed at address 0x10 of the controller's register map. A host reaches it through a serial access path whose address pointer lives here: the host loads the pointer, then issues read or write accesses at the pointed address. Host writes set two control bits, init mode and address auto-decrement. A third bit, the reset request, fires a software reset and does not stay set. The other bit positions report the live condition of the controller: bus-off, transmit and receive warning levels, transmission done and reception in progress.

The init-mode bit opens write access to the four configuration registers, which are the two bit-timing registers, the output-control register and the baud-rate prescaler, at addresses 0x04 to 0x07. While the bit is clear, writes to those addresses never reach the configuration side. A reset request written together with init mode is a hard software reset and clears this register. A reset request without init mode is a soft software reset and keeps the control bits. When auto-decrement is on, every access steps the pointer down by one, so a run of bytes can be read or written after sending a single address.

Top module: `can_mode_status`

## Requirements
- R1: After a synchronous reset, the register byte reads 0x00, the pointer is 0x00, and `cfg_we`, `cfg_access_en`, `soft_rst_p` and `hard_rst_p` are low.
- R2: The register byte places auto-decrement at bit 7, receive-in-progress at bit 6, transmission-complete at bit 5, transmit warning at bit 4, receive warning at bit 3, bus-off at bit 2, reset request at bit 1 (always reads 0) and init mode at bit 0.
- R3: A write access at pointer 0x10 with bit 1 clear stores bit 0 (init mode) and bit 7 (auto-decrement) one cycle later. Written values at bits 6..2 are ignored, and those positions keep showing controller status.
- R4: A write access whose pointer is in 0x04..0x07 gives a one-cycle `cfg_we` pulse on the next cycle, with `cfg_addr` and `cfg_wdata` holding the pointer and the data, only when init mode is 1. With init mode 0, or any other address, no pulse appears. `cfg_access_en` follows the init-mode bit.
- R5: Writing bit 1 = 1 with bit 0 = 0 at 0x10 gives a one-cycle `soft_rst_p` pulse. Init mode and auto-decrement keep their earlier values.
- R6: Writing bit 1 = 1 with bit 0 = 1 at 0x10 gives a one-cycle `hard_rst_p` pulse and clears the register byte to 0x00.
- R7: Bit 3 reads 1 one cycle after the receive-error count is 96 or more, and 0 one cycle after it is below 96.
- R8: Bit 4 reads 1 one cycle after the transmit-error count is 96 or more, and 0 one cycle after it is below 96.
- R9: Bits 2, 5 and 6 show the bus-off, transmission-done and reception-active inputs one cycle later.
- R10: `ptr_load` loads `ptr_in` into the pointer. With auto-decrement 0, accesses leave the pointer unchanged.
- R11: With auto-decrement 1, each read or write access lowers the pointer by one on the next cycle, wrapping from 0x00 to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_load | input | 1 | Load the serial address pointer |
| ptr_in | input | 8 | New pointer value |
| acc_strobe | input | 1 | One host access at the current pointer |
| acc_wr | input | 1 | Access is a write (1) or a read (0) |
| wdata | input | 8 | Host write data |
| rx_err_cnt | input | 8 | Receive-error count |
| tx_err_cnt | input | 8 | Transmit-error count |
| bus_off | input | 1 | Controller is bus-off |
| tx_done | input | 1 | Last transmit request completed successfully |
| rx_active | input | 1 | Frame reception in progress |
| msr_byte | output | 8 | Register byte as read by the host |
| ptr_q | output | 8 | Current serial address pointer |
| cfg_access_en | output | 1 | Configuration registers are writable |
| cfg_we | output | 1 | Gated configuration write pulse |
| cfg_addr | output | 8 | Address of the gated configuration write |
| cfg_wdata | output | 8 | Data of the gated configuration write |
| soft_rst_p | output | 1 | Soft software reset pulse |
| hard_rst_p | output | 1 | Hard software reset pulse |

## Verification
On every cycle the assertions check the reset pulse rules (soft keeps the control bits, hard clears them, never both at once, one cycle wide), the init-mode gate on configuration writes, pointer stepping with and without auto-decrement, and the warning thresholds. The scenarios alone show the full bit layout of the byte, the ignored read-only positions, the exact configuration address window at both edges, the pointer wrap at zero and the status vectors around the 95/96 boundary.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int BYTE_W    = 8;
  localparam int B_IM      = 0;
  localparam int B_RES     = 1;
  localparam int B_BUSOFF  = 2;
  localparam int B_RXWARN  = 3;
  localparam int B_TXWARN  = 4;
  localparam int B_TXDONE  = 5;
  localparam int B_RXACT   = 6;
  localparam int B_ADE     = 7;

  typedef struct packed {
    logic rx_act;
    logic tx_done;
    logic tx_warn;
    logic rx_warn;
    logic bus_off;
  } stat_t;
endpackage

// File: rtl/msr_addr_ptr.sv
module msr_addr_ptr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              access,
  input  logic              dec_en,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (load)
      ptr <= load_val;
    else if (access && dec_en)
      ptr <= ptr - STEP;
  end

  p_dec_r11: assert property (@(posedge clk) disable iff (rst)
    (access && dec_en && !load) |=> (ptr == $past(ptr) - STEP));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!load && !(access && dec_en)) |=> $stable(ptr));
endmodule

// File: rtl/msr_status.sv
module msr_status
  import msr_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int WARN_LIMIT = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rec,
  input  logic [CNT_W-1:0] tec,
  input  logic             bus_off,
  input  logic             tx_done,
  input  logic             rx_active,
  output stat_t            stat
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WARN_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
    end else begin
      stat.rx_warn <= (rec >= LIMIT);
      stat.tx_warn <= (tec >= LIMIT);
      stat.bus_off <= bus_off;
      stat.tx_done <= tx_done;
      stat.rx_act  <= rx_active;
    end
  end

  p_rxwarn_r7: assert property (@(posedge clk) disable iff (rst)
    (rec < LIMIT) |=> !stat.rx_warn);
  p_txwarn_r8: assert property (@(posedge clk) disable iff (rst)
    (tec < LIMIT) |=> !stat.tx_warn);
endmodule

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CFG_BASE  = 4,
  parameter int CFG_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic              wr_any,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              im_q,
  output logic              ade_q,
  output logic              soft_p,
  output logic              hard_p,
  output logic              cfg_we,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [BYTE_W-1:0] cfg_wdata
);
  logic [CFG_COUNT-1:0] cfg_match;
  logic                 in_cfg;

  for (genvar i = 0; i < CFG_COUNT; i++) begin : g_cfg_match
    assign cfg_match[i] = (ptr == ADDR_W'(CFG_BASE + i));
  end
  assign in_cfg = |cfg_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      im_q   <= 1'b0;
      ade_q  <= 1'b0;
      soft_p <= 1'b0;
      hard_p <= 1'b0;
    end else begin
      soft_p <= 1'b0;
      hard_p <= 1'b0;
      if (wr_hit) begin
        if (wdata[B_RES]) begin
          if (wdata[B_IM]) begin
            hard_p <= 1'b1;
            im_q   <= 1'b0;
            ade_q  <= 1'b0;
          end else begin
            soft_p <= 1'b1;
          end
        end else begin
          im_q  <= wdata[B_IM];
          ade_q <= wdata[B_ADE];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_we    <= 1'b0;
      cfg_addr  <= '0;
      cfg_wdata <= '0;
    end else begin
      cfg_we <= wr_any && in_cfg && im_q;
      if (wr_any && in_cfg && im_q) begin
        cfg_addr  <= ptr;
        cfg_wdata <= wdata;
      end
    end
  end

  p_write_store_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !wdata[B_RES]) |=> (im_q == $past(wdata[B_IM]) && ade_q == $past(wdata[B_ADE])));
  p_cfg_gate_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> $past(im_q));
  p_soft_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wdata[B_RES] && !wdata[B_IM]) |=> (soft_p && $stable(im_q) && $stable(ade_q)));
  p_hard_clear_r6: assert property (@(posedge clk) disable iff (rst)
    hard_p |-> (!im_q && !ade_q));
  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(soft_p && hard_p));
  p_pulse_once_r5: assert property (@(posedge clk) disable iff (rst)
    soft_p |=> !soft_p);
endmodule

// File: rtl/can_mode_status.sv
module can_mode_status
  import msr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 8,
  parameter int MSR_ADDR   = 16,
  parameter int CFG_BASE   = 4,
  parameter int CFG_COUNT  = 4,
  parameter int WARN_LIMIT = 96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_in,
  input  logic              acc_strobe,
  input  logic              acc_wr,
  input  logic [7:0]        wdata,
  input  logic [CNT_W-1:0]  rx_err_cnt,
  input  logic [CNT_W-1:0]  tx_err_cnt,
  input  logic              bus_off,
  input  logic              tx_done,
  input  logic              rx_active,
  output logic [7:0]        msr_byte,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              cfg_access_en,
  output logic              cfg_we,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [7:0]        cfg_wdata,
  output logic              soft_rst_p,
  output logic              hard_rst_p
);
  localparam logic [ADDR_W-1:0] MSR_A = ADDR_W'(MSR_ADDR);

  stat_t stat;
  logic  im_q, ade_q, wr_any, wr_hit;

  assign wr_any = acc_strobe && acc_wr && !ptr_load;
  assign wr_hit = wr_any && (ptr_q == MSR_A);

  msr_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_in),
    .access(acc_strobe), .dec_en(ade_q), .ptr(ptr_q)
  );

  msr_status #(.CNT_W(CNT_W), .WARN_LIMIT(WARN_LIMIT)) u_stat (
    .clk(clk), .rst(rst), .rec(rx_err_cnt), .tec(tx_err_cnt),
    .bus_off(bus_off), .tx_done(tx_done), .rx_active(rx_active), .stat(stat)
  );

  msr_ctrl #(.ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .CFG_COUNT(CFG_COUNT)) u_ctrl (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .wr_any(wr_any), .ptr(ptr_q),
    .wdata(wdata), .im_q(im_q), .ade_q(ade_q), .soft_p(soft_rst_p),
    .hard_p(hard_rst_p), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  always_comb begin
    msr_byte           = '0;
    msr_byte[B_IM]     = im_q;
    msr_byte[B_RES]    = 1'b0;
    msr_byte[B_BUSOFF] = stat.bus_off;
    msr_byte[B_RXWARN] = stat.rx_warn;
    msr_byte[B_TXWARN] = stat.tx_warn;
    msr_byte[B_TXDONE] = stat.tx_done;
    msr_byte[B_RXACT]  = stat.rx_act;
    msr_byte[B_ADE]    = ade_q;
  end

  assign cfg_access_en = im_q;

  p_res_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !msr_byte[B_RES]);
  p_cfg_en_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_access_en == msr_byte[B_IM]);
endmodule

// File: tb/tb_can_mode_status.sv
module tb_can_mode_status;
  logic       clk = 1'b0;
  logic       rst;
  logic       ptr_load, acc_strobe, acc_wr;
  logic [7:0] ptr_in, wdata, rx_err_cnt, tx_err_cnt;
  logic       bus_off, tx_done, rx_active;
  logic [7:0] msr_byte, ptr_q, cfg_addr, cfg_wdata;
  logic       cfg_access_en, cfg_we, soft_rst_p, hard_rst_p;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  can_mode_status dut (
    .clk(clk), .rst(rst), .ptr_load(ptr_load), .ptr_in(ptr_in),
    .acc_strobe(acc_strobe), .acc_wr(acc_wr), .wdata(wdata),
    .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt), .bus_off(bus_off),
    .tx_done(tx_done), .rx_active(rx_active), .msr_byte(msr_byte),
    .ptr_q(ptr_q), .cfg_access_en(cfg_access_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .soft_rst_p(soft_rst_p),
    .hard_rst_p(hard_rst_p)
  );

  // {rec, tec, bus_off, tx_done, rx_active, expected byte[6:2]}
  localparam logic [23:0] VEC [8] = '{
    {8'd0,   8'd0,   1'b0, 1'b0, 1'b0, 5'b00000},
    {8'd95,  8'd95,  1'b0, 1'b0, 1'b0, 5'b00000},
    {8'd96,  8'd0,   1'b0, 1'b0, 1'b0, 5'b00010},
    {8'd0,   8'd96,  1'b0, 1'b0, 1'b0, 5'b00100},
    {8'd255, 8'd200, 1'b1, 1'b0, 1'b0, 5'b00111},
    {8'd0,   8'd0,   1'b0, 1'b1, 1'b0, 5'b01000},
    {8'd0,   8'd0,   1'b0, 1'b0, 1'b1, 5'b10000},
    {8'd97,  8'd96,  1'b1, 1'b1, 1'b1, 5'b11111}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic load_ptr(input logic [7:0] a);
    @(negedge clk);
    ptr_load = 1'b1; ptr_in = a;
    @(negedge clk);
    ptr_load = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [7:0] d);
    @(negedge clk);
    acc_strobe = 1'b1; acc_wr = wr; wdata = d;
    @(negedge clk);
    acc_strobe = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    rst = 1'b1; ptr_load = 0; ptr_in = 0; acc_strobe = 0; acc_wr = 0; wdata = 0;
    rx_err_cnt = 0; tx_err_cnt = 0; bus_off = 0; tx_done = 0; rx_active = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 byte", msr_byte, 8'h00);
    chk("R1 ptr", ptr_q, 8'h00);
    chk("R1 pulses", {4'b0, cfg_we, cfg_access_en, soft_rst_p, hard_rst_p}, 8'h00);

    // R7 R8 R9 R2 status vectors
    foreach (VEC[i]) begin
      @(negedge clk);
      {rx_err_cnt, tx_err_cnt, bus_off, tx_done, rx_active} = VEC[i][23:5];
      @(negedge clk);
      chk("R7/R8/R9 status bits", {3'b0, msr_byte[6:2]}, {3'b0, VEC[i][4:0]});
      chk("R2 unused zero", {6'b0, msr_byte[1], msr_byte[0]}, 8'h00);
    end
    @(negedge clk);
    {rx_err_cnt, tx_err_cnt, bus_off, tx_done, rx_active} = '0;
    @(negedge clk);

    // R4: init mode clear blocks config writes
    load_ptr(8'h05);
    access(1'b1, 8'hAA);
    chk("R4 blocked", {7'b0, cfg_we}, 8'h00);

    // R3: set init mode; read-only positions ignored
    load_ptr(8'h10);
    access(1'b1, 8'h7D);
    chk("R3 stored/ignored", msr_byte, 8'h01);
    chk("R4 cfg_access_en", {7'b0, cfg_access_en}, 8'h01);
    chk("R10 ptr hold on write", ptr_q, 8'h10);

    // R4: config window edges
    load_ptr(8'h05);
    access(1'b1, 8'h5A);
    chk("R4 we", {7'b0, cfg_we}, 8'h01);
    chk("R4 addr", cfg_addr, 8'h05);
    chk("R4 data", cfg_wdata, 8'h5A);
    @(negedge clk);
    chk("R4 one cycle", {7'b0, cfg_we}, 8'h00);
    load_ptr(8'h04);
    access(1'b1, 8'h11);
    chk("R4 low edge", {cfg_we, cfg_addr[6:0]}, 8'h84);
    load_ptr(8'h07);
    access(1'b1, 8'h22);
    chk("R4 high edge", {cfg_we, cfg_addr[6:0]}, 8'h87);
    load_ptr(8'h08);
    access(1'b1, 8'h33);
    chk("R4 outside high", {7'b0, cfg_we}, 8'h00);
    load_ptr(8'h03);
    access(1'b1, 8'h33);
    chk("R4 outside low", {7'b0, cfg_we}, 8'h00);
    load_ptr(8'h06);
    access(1'b0, 8'h33);
    chk("R4 read no we", {7'b0, cfg_we}, 8'h00);

    // R3: set ADE too
    load_ptr(8'h10);
    access(1'b1, 8'h81);
    chk("R3 ade+im", msr_byte, 8'h81);

    // R5: soft reset keeps IM and ADE
    load_ptr(8'h10);
    access(1'b1, 8'h02);
    chk("R5 soft pulse", {6'b0, soft_rst_p, hard_rst_p}, 8'h02);
    chk("R5 bits kept", msr_byte, 8'h81);
    @(negedge clk);
    chk("R5 pulse ends", {6'b0, soft_rst_p, hard_rst_p}, 8'h00);

    // R6: hard reset clears
    load_ptr(8'h10);
    access(1'b1, 8'h83);
    chk("R6 hard pulse", {6'b0, soft_rst_p, hard_rst_p}, 8'h01);
    chk("R6 cleared", msr_byte, 8'h00);
    @(negedge clk);
    chk("R6 pulse ends", {6'b0, soft_rst_p, hard_rst_p}, 8'h00);

    // R10: no decrement without ADE
    load_ptr(8'h02);
    chk("R10 load", ptr_q, 8'h02);
    access(1'b0, 8'h00);
    chk("R10 hold on read", ptr_q, 8'h02);

    // R11: decrement and wrap
    load_ptr(8'h10);
    access(1'b1, 8'h80);
    chk("R11 ade set, ptr not yet stepping", ptr_q, 8'h10);
    load_ptr(8'h01);
    access(1'b0, 8'h00);
    chk("R11 dec", ptr_q, 8'h00);
    access(1'b0, 8'h00);
    chk("R11 wrap", ptr_q, 8'hFF);
    access(1'b1, 8'h00);
    chk("R11 dec on write", ptr_q, 8'hFE);

    // R1: reset again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 re-reset byte", msr_byte, 8'h00);
    chk("R1 re-reset ptr", ptr_q, 8'h00);

    summary();
  end
endmodule